// File: doc/BRIEF.md
# PCM Receive Status Flag Register

This block holds the receive-side status word of a stereo audio codec link. It raises sticky flags when the link front end reports that a codec status address or a codec status data word has arrived. It raises a request flag when a new left-channel (slot 3) or right-channel (slot 4) sample has been captured. It raises an overrun flag when a new sample for a channel lands before the previous sample of that channel has been consumed. The front end supplies single-cycle strobes for these events. The block itself does no framing, no slot extraction and no sample storage.

A host reads the whole word combinationally through `rd_data`. It clears flags by writing the word back with a 0 in each bit it wants to clear. A 1 leaves a bit as it is, so writing all ones is a harmless no-op. The two request flags are also driven out as levels, `left_req` and `right_req`, so a DMA engine or an interrupt controller can use them directly. When `dma_mode` is high, a read strobe on a channel's sample register consumes that sample and drops its request flag by itself. All pins are plain control and status signals. No data stream crosses the block's boundary, so it has no valid/ready handshake and never applies back-pressure.

Top module: `pcm_rx_status`

## Requirements
- R1: After reset (rst_n low), `rd_data` is 0 and `left_req` and `right_req` are 0.
- R2: Bits 31..23, 18..14 and 11..0 of `rd_data` always read 0, whatever was written to them.
- R3: `sts_addr_stb` sets bit 22 and `sts_data_stb` sets bit 21. Each bit is visible in `rd_data` from the clock edge at which its strobe is sampled.
- R4: `left_new` sets bit 20 (left request) and `right_new` sets bit 19 (right request). `left_req` and `right_req` always equal bits 20 and 19.
- R5: A cycle with `wr_en` high clears every defined flag (bits 22, 21, 20, 19, 13, 12) whose bit in `wr_data` is 0. Flags whose `wr_data` bit is 1 keep their value.
- R6: With `dma_mode` high, `left_rd` clears bit 20 and `right_rd` clears bit 19 at the next clock edge.
- R7: With `dma_mode` low, `left_rd` and `right_rd` change no bit of the register.
- R8: A channel's overrun bit (bit 13 left, bit 12 right) is set when a new sample of that channel is sampled while its request bit is 1. The exception is a cycle in which that same channel is also being read with `dma_mode` high: the sample being replaced is consumed in that cycle, so no overrun is raised.
- R9: An overrun bit stays set through any number of data-register reads, in either mode. Only a host write of 0 to it clears it.
- R10: When a set event and a clear (a host write of 0, or a DMA-mode read) hit the same flag in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sts_addr_stb | input | 1 | Codec status address captured |
| sts_data_stb | input | 1 | Codec status data captured |
| left_new | input | 1 | New left-channel (slot 3) sample captured |
| right_new | input | 1 | New right-channel (slot 4) sample captured |
| left_rd | input | 1 | Left sample register is being read |
| right_rd | input | 1 | Right sample register is being read |
| dma_mode | input | 1 | Reads consume the sample and drop its request |
| wr_en | input | 1 | Host write of the status word |
| wr_data | input | 32 | Host write data; a 0 bit clears that flag |
| rd_data | output | 32 | Current status word |
| left_req | output | 1 | Level request for the left channel |
| right_req | output | 1 | Level request for the right channel |

## Verification
The bench builds the block with its default parameters: a 32-bit word, two channels, and flags at bits 22, 21, 20, 19, 13 and 12. With those values, exact word comparisons show in one view whether a reserved position ever leaks a 1 and whether a write of all ones disturbs any flag. The sequence drives a concurrent DMA read and new sample on one channel, and a clearing write together with new events, so both directions of the set-over-clear priority are checked. It also returns overrun flags through reads in both modes to show that they persist until a host write clears them.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned NUM_CH = 2;

  // Flag positions decoded by host software.
  localparam int unsigned POS_SADDR = 22;
  localparam int unsigned POS_SDATA = 21;
  localparam int unsigned POS_REQ_L = 20;
  localparam int unsigned POS_REQ_R = 19;
  localparam int unsigned POS_OVR_L = 13;
  localparam int unsigned POS_OVR_R = 12;

  typedef struct packed {
    logic req;
    logic ovr;
  } chan_flags_t;

  typedef struct packed {
    logic fresh;    // new sample captured
    logic rd;       // sample register read
  } chan_evt_t;

  function automatic int unsigned req_pos(input int unsigned ch);
    return (ch == 0) ? POS_REQ_L : POS_REQ_R;
  endfunction

  function automatic int unsigned ovr_pos(input int unsigned ch);
    return (ch == 0) ? POS_OVR_L : POS_OVR_R;
  endfunction
endpackage

// File: rtl/rxstat_flag.sv
module rxstat_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic q_o
);
  logic host_clr;
  assign host_clr = wr_en_i && !wr_bit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      q_o <= 1'b0;
    else if (set_i)                  q_o <= 1'b1;
    else if (host_clr || hw_clr_i)   q_o <= 1'b0;
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  // R5
  wr_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_bit_i && !hw_clr_i && !set_i) |=> (q_o == $past(q_o)));

  // R5
  wr_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_clr && !set_i) |=> !q_o);
endmodule

// File: rtl/rxstat_chan.sv
module rxstat_chan
  import rxstat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  chan_evt_t   evt_i,
  input  logic        dma_mode_i,
  input  logic        wr_en_i,
  input  logic        wr_req_bit_i,
  input  logic        wr_ovr_bit_i,
  output chan_flags_t flags_o
);
  logic consume;
  logic ovr_set;

  // A read consumes the sample only in DMA mode.
  assign consume = dma_mode_i && evt_i.rd;
  // New sample while the old one is still pending and not being consumed.
  assign ovr_set = evt_i.fresh && flags_o.req && !consume;

  rxstat_flag u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (evt_i.fresh),
    .hw_clr_i (consume),
    .wr_en_i  (wr_en_i),
    .wr_bit_i (wr_req_bit_i),
    .q_o      (flags_o.req)
  );

  rxstat_flag u_ovr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (ovr_set),
    .hw_clr_i (1'b0),
    .wr_en_i  (wr_en_i),
    .wr_bit_i (wr_ovr_bit_i),
    .q_o      (flags_o.ovr)
  );

  // R6
  dma_rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode_i && evt_i.rd && !evt_i.fresh) |=> !flags_o.req);

  // R7
  nodma_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_mode_i && flags_o.req && !(wr_en_i && !wr_req_bit_i)) |=> flags_o.req);

  // R8
  ovr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.fresh && flags_o.req && !(dma_mode_i && evt_i.rd)) |=> flags_o.ovr);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o.ovr && !(wr_en_i && !wr_ovr_bit_i)) |=> flags_o.ovr);
endmodule

// File: rtl/pcm_rx_status.sv
module pcm_rx_status
  import rxstat_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sts_addr_stb,
  input  logic              sts_data_stb,
  input  logic              left_new,
  input  logic              right_new,
  input  logic              left_rd,
  input  logic              right_rd,
  input  logic              dma_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              left_req,
  output logic              right_req
);
  localparam logic [DATA_W-1:0] DEF_MASK =
      (DATA_W'(1) << POS_SADDR) | (DATA_W'(1) << POS_SDATA) |
      (DATA_W'(1) << POS_REQ_L) | (DATA_W'(1) << POS_REQ_R) |
      (DATA_W'(1) << POS_OVR_L) | (DATA_W'(1) << POS_OVR_R);

  chan_evt_t   evt   [NUM_CH];
  chan_flags_t flags [NUM_CH];
  logic        saddr_q;
  logic        sdata_q;
  logic        unused_wr_bits;

  assign evt[0] = '{fresh: left_new,  rd: left_rd};
  assign evt[1] = '{fresh: right_new, rd: right_rd};

  rxstat_flag u_saddr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (sts_addr_stb),
    .hw_clr_i (1'b0),
    .wr_en_i  (wr_en),
    .wr_bit_i (wr_data[POS_SADDR]),
    .q_o      (saddr_q)
  );

  rxstat_flag u_sdata (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (sts_data_stb),
    .hw_clr_i (1'b0),
    .wr_en_i  (wr_en),
    .wr_bit_i (wr_data[POS_SDATA]),
    .q_o      (sdata_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    rxstat_chan u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_i        (evt[c]),
      .dma_mode_i   (dma_mode),
      .wr_en_i      (wr_en),
      .wr_req_bit_i (wr_data[req_pos(c)]),
      .wr_ovr_bit_i (wr_data[ovr_pos(c)]),
      .flags_o      (flags[c])
    );
  end

  always_comb begin
    rd_data = '0;
    rd_data[POS_SADDR] = saddr_q;
    rd_data[POS_SDATA] = sdata_q;
    for (int c = 0; c < NUM_CH; c++) begin
      rd_data[req_pos(c)] = flags[c].req;
      rd_data[ovr_pos(c)] = flags[c].ovr;
    end
  end

  assign left_req  = flags[0].req;
  assign right_req = flags[1].req;

  // Reserved write bits are ignored by design.
  assign unused_wr_bits = ^(wr_data & ~DEF_MASK);

  // R3
  saddr_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_addr_stb |=> rd_data[POS_SADDR]);

  // R3
  sdata_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_data_stb |=> rd_data[POS_SDATA]);

  // R4
  req_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_new || right_new) |=> ((left_req || !$past(left_new)) && (right_req || !$past(right_new))));
endmodule

// File: tb/test_pcm_rx_status.sv
module test_pcm_rx_status;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYC   = 2000;

  typedef struct {
    logic [31:0] data;
    logic        lreq;
    logic        rreq;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sts_addr_stb = 1'b0, sts_data_stb = 1'b0;
  logic        left_new = 1'b0, right_new = 1'b0;
  logic        left_rd = 1'b0, right_rd = 1'b0;
  logic        dma_mode = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '1;
  logic [31:0] rd_data;
  logic        left_req, right_req;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_rx_status i_pcm_rx_status (
    .clk (clk), .rst_n (rst_n),
    .sts_addr_stb (sts_addr_stb), .sts_data_stb (sts_data_stb),
    .left_new (left_new), .right_new (right_new),
    .left_rd (left_rd), .right_rd (right_rd),
    .dma_mode (dma_mode), .wr_en (wr_en), .wr_data (wr_data),
    .rd_data (rd_data), .left_req (left_req), .right_req (right_req)
  );

  // Monitor: compares each queued expectation at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (rd_data !== e.data || left_req !== e.lreq || right_req !== e.rreq) begin
          errors++;
          $display("FAIL %s: rd_data=%h lreq=%b rreq=%b expected %h %b %b",
                   e.tag, rd_data, left_req, right_req, e.data, e.lreq, e.rreq);
        end
      end
    end
  end

  // Driver: hold stimulus for one edge, then queue the expected state.
  task automatic step(input logic sa, input logic sd, input logic ln, input logic rn,
                      input logic lr, input logic rr, input logic dm,
                      input logic we, input logic [31:0] wd,
                      input logic [31:0] exp_d, input string tag);
    exp_t e;
    @(negedge clk);
    #1;
    sts_addr_stb = sa; sts_data_stb = sd; left_new = ln; right_new = rn;
    left_rd = lr; right_rd = rr; dma_mode = dm; wr_en = we; wr_data = wd;
    @(posedge clk);
    #1;
    sts_addr_stb = 0; sts_data_stb = 0; left_new = 0; right_new = 0;
    left_rd = 0; right_rd = 0; wr_en = 0; wr_data = '1;
    e.data = exp_d; e.lreq = exp_d[20]; e.rreq = exp_d[19]; e.tag = tag;
    sb_q.push_back(e);
  endtask

  initial begin
    exp_t e;
    repeat (3) @(posedge clk);
    #1;
    e.data = '0; e.lreq = 0; e.rreq = 0; e.tag = "R1 reset";
    sb_q.push_back(e);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    //   sa sd ln rn lr rr dm we wd            expected
    step(1, 0, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h0040_0000, "R3 status address");
    step(0, 1, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h0060_0000, "R3 status data");
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, 32'h0060_0000, "R2 R5 write ones");
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'hFFBF_FFFF, 32'h0020_0000, "R5 clear bit 22");
    step(0, 0, 1, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h0030_0000, "R4 left request");
    step(0, 0, 0, 1, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h0038_0000, "R4 right request");
    step(0, 0, 0, 0, 1, 1, 0, 0, 32'hFFFF_FFFF, 32'h0038_0000, "R7 read without DMA");
    step(0, 0, 1, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h0038_2000, "R8 left overrun");
    step(0, 0, 0, 0, 1, 0, 1, 0, 32'hFFFF_FFFF, 32'h0028_2000, "R6 DMA read left");
    step(0, 0, 0, 0, 1, 0, 1, 0, 32'hFFFF_FFFF, 32'h0028_2000, "R9 overrun survives read");
    step(0, 0, 0, 1, 0, 1, 1, 0, 32'hFFFF_FFFF, 32'h0028_2000, "R10 R8 DMA read with new sample");
    step(0, 0, 0, 1, 0, 0, 1, 0, 32'hFFFF_FFFF, 32'h0028_3000, "R8 right overrun");
    step(0, 0, 0, 0, 0, 1, 0, 0, 32'hFFFF_FFFF, 32'h0028_3000, "R9 overrun survives non-DMA read");
    step(0, 0, 1, 0, 0, 0, 0, 1, 32'h0000_0000, 32'h0010_0000, "R10 R5 set beats write zero");
    step(1, 0, 0, 0, 0, 0, 0, 1, 32'h0000_0000, 32'h0040_0000, "R10 status set beats write zero");
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_0000, 32'h0000_0000, "R5 clear all");
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, 32'h0000_0000, "R2 reserved stay zero");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule